// File: doc/BRIEF.md
# Serial Transfer FIFO Pair with Interrupt and DMA Levels

This block holds the two data queues that sit between a host bus and a serial shifter. The bus side pushes outgoing frames through a write strobe and pulls incoming frames through a read strobe that shares one data register. The shifter side pops outgoing frames and pushes incoming frames. Each queue entry carries one frame, right-justified in a 32-bit word. There is no packing of several frames into one word.

Around the queues the block derives five interrupt sources. Two are level-style threshold indications: the transmit side asks for refill, and the receive side asks for draining. The other three are sticky error flags: transmit overflow, receive overflow and receive underflow. Each sticky flag is cleared by its own read-to-clear strobe. Every source passes through its own enable bit into a single combined interrupt line. The raw source vector is exposed as well. Two DMA request lines follow their own watermark levels and their own enables. Both occupancy counts are outputs.

Top module: `sfifo_pair`

## Requirements
- R1: Each queue holds DEPTH (8) entries of 32 bits in first-in first-out order. `tx_count` and `rx_count` report the occupancy, which runs from 0 to 8. A bus read updates `bus_rdata` one cycle after `bus_rd`. `sh_tx_data` shows the current transmit head.
- R2: Raw bit 0 (transmit refill) is 1 exactly when `tx_count <= tx_thresh`.
- R3: Raw bit 4 (receive drain) is 1 exactly when `rx_count >= rx_thresh + 1`.
- R4: A bus write while the transmit queue is full, with no shifter pop in the same cycle, is discarded. It sets sticky raw bit 1. A `clr_txo` strobe clears bit 1, except that a new set in the same cycle wins over the clear.
- R5: A shifter push while the receive queue is full, with no bus read in the same cycle, loses the frame. It sets sticky raw bit 3, which `clr_rxo` clears.
- R6: A bus read while the receive queue is empty, with no shifter push in the same cycle, returns zero on `bus_rdata`. It sets sticky raw bit 2, which `clr_rxu` clears. A set in the same cycle as the clear wins.
- R7: `dma_tx_req` is 1 exactly when `dma_tx_en` is 1 and `tx_count <= dma_tx_lvl`.
- R8: `dma_rx_req` is 1 exactly when `dma_rx_en` is 1 and `rx_count >= dma_rx_lvl + 1`.
- R9: `irq_masked` is the raw vector ANDed bitwise with `irq_en`. `irq` is the OR of `irq_masked`.
- R10: A push and a pop in the same cycle on a full queue, or on an empty queue, keep the count unchanged and raise no error flag. On an empty receive queue the pushed frame passes straight to `bus_rdata`.
- R11: After reset both counts are 0, all sticky flags are 0 and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write of one transmit frame |
| bus_wdata | input | 32 | Transmit frame from the bus |
| bus_rd | input | 1 | Bus read of one receive frame |
| bus_rdata | output | 32 | Registered receive frame to the bus |
| sh_tx_pop | input | 1 | Shifter takes the transmit head |
| sh_tx_data | output | 32 | Transmit head frame |
| sh_rx_push | input | 1 | Shifter delivers a receive frame |
| sh_rx_data | input | 32 | Receive frame from the shifter |
| tx_thresh | input | 4 | Transmit refill threshold |
| rx_thresh | input | 4 | Receive drain threshold |
| dma_tx_lvl | input | 4 | Transmit DMA watermark |
| dma_rx_lvl | input | 4 | Receive DMA watermark |
| dma_tx_en | input | 1 | Transmit DMA request enable |
| dma_rx_en | input | 1 | Receive DMA request enable |
| irq_en | input | 5 | Per-source interrupt enables |
| clr_txo | input | 1 | Read-to-clear strobe, transmit overflow |
| clr_rxo | input | 1 | Read-to-clear strobe, receive overflow |
| clr_rxu | input | 1 | Read-to-clear strobe, receive underflow |
| tx_count | output | 4 | Transmit occupancy |
| rx_count | output | 4 | Receive occupancy |
| irq_raw | output | 5 | Unmasked sources: 0 refill, 1 tx overflow, 2 underflow, 3 rx overflow, 4 drain |
| irq_masked | output | 5 | Enabled sources |
| irq | output | 1 | Combined interrupt |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The bench builds the block with its default parameters: 32-bit frames and a depth of 8. With a depth of 8, the full and empty boundaries are reached in a few cycles. The counts reach every value from 0 to 8, and the nine-write and nine-push overflow runs exercise the overflow and wrap paths. The threshold and watermark inputs are set to small values, so each comparison crosses its boundary in both directions inside short sequences.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 8;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NSRC   = 5;

    typedef enum int {
        SRC_TX_REFILL = 0,
        SRC_TX_OVF    = 1,
        SRC_RX_UNF    = 2,
        SRC_RX_OVF    = 3,
        SRC_RX_DRAIN  = 4
    } src_idx_e;

    typedef logic [DATA_W-1:0] frame_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic tx_ovf;
        logic rx_ovf;
        logic rx_unf;
    } err_set_t;

    function automatic logic at_or_below(input cnt_t cnt, input cnt_t lvl);
        return cnt <= lvl;
    endfunction

    function automatic logic above_level(input cnt_t cnt, input cnt_t lvl);
        return {1'b0, cnt} >= ({1'b0, lvl} + 1'b1);
    endfunction
endpackage

// File: rtl/sfifo_ring.sv
module sfifo_ring
    import sfifo_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int D = DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             dropped,
    output logic             starved
);
    localparam int PW = (D > 1) ? $clog2(D) : 1;

    logic [W-1:0]  mem [D];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          full, empty, push_ok, pop_ok;

    assign full    = (count == CNT_W'(D));
    assign empty   = (count == '0);
    assign push_ok = push && (!full || pop);
    assign pop_ok  = pop && (!empty || push);
    assign dropped = push && full && !pop;
    assign starved = pop && empty && !push;
    assign head    = empty ? push_data : mem[rd_ptr];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(D - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(D)) else $error("count beyond depth"); // R1
    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (rst)
        (full && push && pop) |=> count == CNT_W'(D)) else $error("full swap moved count"); // R10
    AST_EMPTY_PASS: assert property (@(posedge clk) disable iff (rst)
        (empty && push && pop) |=> count == '0) else $error("empty pass moved count"); // R10
    AST_DROP_HOLD: assert property (@(posedge clk) disable iff (rst)
        dropped |=> count == CNT_W'(D)) else $error("drop changed count"); // R4
endmodule

// File: rtl/sfifo_irq.sv
module sfifo_irq
    import sfifo_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  cnt_t            tx_count,
    input  cnt_t            rx_count,
    input  cnt_t            tx_thresh,
    input  cnt_t            rx_thresh,
    input  cnt_t            dma_tx_lvl,
    input  cnt_t            dma_rx_lvl,
    input  logic            dma_tx_en,
    input  logic            dma_rx_en,
    input  err_set_t        err_set,
    input  logic            clr_txo,
    input  logic            clr_rxo,
    input  logic            clr_rxu,
    input  logic [NSRC-1:0] irq_en,
    output logic [NSRC-1:0] irq_raw,
    output logic [NSRC-1:0] irq_masked,
    output logic            irq,
    output logic            dma_tx_req,
    output logic            dma_rx_req
);
    err_set_t sticky;

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky <= '0;
        end else begin
            sticky.tx_ovf <= err_set.tx_ovf | (sticky.tx_ovf & ~clr_txo);
            sticky.rx_ovf <= err_set.rx_ovf | (sticky.rx_ovf & ~clr_rxo);
            sticky.rx_unf <= err_set.rx_unf | (sticky.rx_unf & ~clr_rxu);
        end
    end

    always_comb begin
        irq_raw                = '0;
        irq_raw[SRC_TX_REFILL] = at_or_below(tx_count, tx_thresh);
        irq_raw[SRC_TX_OVF]    = sticky.tx_ovf;
        irq_raw[SRC_RX_UNF]    = sticky.rx_unf;
        irq_raw[SRC_RX_OVF]    = sticky.rx_ovf;
        irq_raw[SRC_RX_DRAIN]  = above_level(rx_count, rx_thresh);
    end

    assign irq_masked = irq_raw & irq_en;
    assign irq        = |irq_masked;
    assign dma_tx_req = dma_tx_en && at_or_below(tx_count, dma_tx_lvl);
    assign dma_rx_req = dma_rx_en && above_level(rx_count, dma_rx_lvl);

    AST_TXO_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sticky.tx_ovf && !clr_txo) |=> sticky.tx_ovf) else $error("txo lost"); // R4
    AST_TXO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_txo && !err_set.tx_ovf) |=> !sticky.tx_ovf) else $error("txo not cleared"); // R4
    AST_RXO_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sticky.rx_ovf && !clr_rxo) |=> sticky.rx_ovf) else $error("rxo lost"); // R5
    AST_RXU_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sticky.rx_unf && !clr_rxu) |=> sticky.rx_unf) else $error("rxu lost"); // R6
    AST_RXU_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        err_set.rx_unf |=> sticky.rx_unf) else $error("rxu set missed"); // R6
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> !irq) else $error("irq with all disabled"); // R9
    AST_DMA_TX_GATE: assert property (@(posedge clk) disable iff (rst)
        !dma_tx_en |-> !dma_tx_req) else $error("tx dma ungated"); // R7
    AST_DMA_RX_GATE: assert property (@(posedge clk) disable iff (rst)
        !dma_rx_en |-> !dma_rx_req) else $error("rx dma ungated"); // R8
endmodule

// File: rtl/sfifo_pair.sv
module sfifo_pair
    import sfifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sh_tx_pop,
    output logic [DATA_W-1:0] sh_tx_data,
    input  logic              sh_rx_push,
    input  logic [DATA_W-1:0] sh_rx_data,
    input  logic [CNT_W-1:0]  tx_thresh,
    input  logic [CNT_W-1:0]  rx_thresh,
    input  logic [CNT_W-1:0]  dma_tx_lvl,
    input  logic [CNT_W-1:0]  dma_rx_lvl,
    input  logic              dma_tx_en,
    input  logic              dma_rx_en,
    input  logic [NSRC-1:0]   irq_en,
    input  logic              clr_txo,
    input  logic              clr_rxo,
    input  logic              clr_rxu,
    output logic [CNT_W-1:0]  tx_count,
    output logic [CNT_W-1:0]  rx_count,
    output logic [NSRC-1:0]   irq_raw,
    output logic [NSRC-1:0]   irq_masked,
    output logic              irq,
    output logic              dma_tx_req,
    output logic              dma_rx_req
);
    frame_t   rx_head;
    err_set_t err_set;
    logic     tx_starved_unused;
    logic     rx_dropped, rx_starved, tx_dropped;

    sfifo_ring #(.W(DATA_W), .D(DEPTH)) u_tx (
        .clk(clk), .rst(rst),
        .push(bus_wr), .push_data(bus_wdata),
        .pop(sh_tx_pop), .head(sh_tx_data),
        .count(tx_count), .dropped(tx_dropped), .starved(tx_starved_unused)
    );

    sfifo_ring #(.W(DATA_W), .D(DEPTH)) u_rx (
        .clk(clk), .rst(rst),
        .push(sh_rx_push), .push_data(sh_rx_data),
        .pop(bus_rd), .head(rx_head),
        .count(rx_count), .dropped(rx_dropped), .starved(rx_starved)
    );

    assign err_set = '{tx_ovf: tx_dropped, rx_ovf: rx_dropped, rx_unf: rx_starved};

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rx_starved ? '0 : rx_head;
    end

    sfifo_irq u_irq (
        .clk(clk), .rst(rst),
        .tx_count(tx_count), .rx_count(rx_count),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
        .dma_tx_lvl(dma_tx_lvl), .dma_rx_lvl(dma_rx_lvl),
        .dma_tx_en(dma_tx_en), .dma_rx_en(dma_rx_en),
        .err_set(err_set),
        .clr_txo(clr_txo), .clr_rxo(clr_rxo), .clr_rxu(clr_rxu),
        .irq_en(irq_en),
        .irq_raw(irq_raw), .irq_masked(irq_masked), .irq(irq),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
    );

    AST_UNF_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && rx_count == '0 && !sh_rx_push) |=> bus_rdata == '0) else $error("underflow data"); // R6
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata)) else $error("rdata moved"); // R1
    AST_TXO_FROM_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_raw[SRC_TX_OVF]) |-> $past(tx_count) == CNT_W'(DEPTH)) else $error("txo when not full"); // R4
endmodule

// File: tb/tb_sfifo_pair.sv
module tb_sfifo_pair;
    import sfifo_pkg::*;

    logic clk = 0;
    always #4 clk = ~clk;

    logic rst, bus_wr, bus_rd, sh_tx_pop, sh_rx_push;
    logic [31:0] bus_wdata, sh_rx_data, bus_rdata, sh_tx_data;
    logic [3:0] tx_thresh, rx_thresh, dma_tx_lvl, dma_rx_lvl, tx_count, rx_count;
    logic dma_tx_en, dma_rx_en, clr_txo, clr_rxo, clr_rxu, irq, dma_tx_req, dma_rx_req;
    logic [4:0] irq_en, irq_raw, irq_masked;

    sfifo_pair dut (.*);

    int n_chk = 0, n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic wr, rd, push, pop;
        logic [31:0] data;
        logic [3:0] etx, erx;
        logic [4:0] eraw;
        logic chkrd;
        logic [31:0] erd;
    } vec_t;

    // raw bits: 0 refill, 1 tx overflow, 2 underflow, 3 rx overflow, 4 drain; thresholds 2/2
    localparam vec_t VECS [12] = '{
        '{1'b1,1'b0,1'b0,1'b0,32'hA1,4'd1,4'd0,5'b00001,1'b0,32'h0},
        '{1'b1,1'b0,1'b0,1'b0,32'hA2,4'd2,4'd0,5'b00001,1'b0,32'h0},
        '{1'b1,1'b0,1'b0,1'b0,32'hA3,4'd3,4'd0,5'b00000,1'b0,32'h0},
        '{1'b0,1'b0,1'b1,1'b0,32'hB1,4'd3,4'd1,5'b00000,1'b0,32'h0},
        '{1'b0,1'b0,1'b1,1'b0,32'hB2,4'd3,4'd2,5'b00000,1'b0,32'h0},
        '{1'b0,1'b0,1'b1,1'b0,32'hB3,4'd3,4'd3,5'b10000,1'b0,32'h0},
        '{1'b0,1'b1,1'b0,1'b0,32'h0 ,4'd3,4'd2,5'b00000,1'b1,32'hB1},
        '{1'b0,1'b0,1'b0,1'b1,32'h0 ,4'd2,4'd2,5'b00001,1'b0,32'h0},
        '{1'b0,1'b1,1'b0,1'b0,32'h0 ,4'd2,4'd1,5'b00001,1'b1,32'hB2},
        '{1'b0,1'b1,1'b0,1'b0,32'h0 ,4'd2,4'd0,5'b00001,1'b1,32'hB3},
        '{1'b0,1'b1,1'b0,1'b0,32'h0 ,4'd2,4'd0,5'b00101,1'b1,32'h0},
        '{1'b1,1'b0,1'b1,1'b0,32'hC1,4'd3,4'd1,5'b00100,1'b0,32'h0}
    };

    task automatic idle();
        bus_wr = 0; bus_rd = 0; sh_tx_pop = 0; sh_rx_push = 0;
        clr_txo = 0; clr_rxo = 0; clr_rxu = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); idle(); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    // drive for one edge, return at the following negedge
    task automatic cyc(input logic wr, input logic [31:0] wd, input logic rd,
                       input logic push, input logic [31:0] pd, input logic pop);
        bus_wr = wr; bus_wdata = wd; bus_rd = rd;
        sh_rx_push = push; sh_rx_data = pd; sh_tx_pop = pop;
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(); rst = 1; bus_wdata = 0; sh_rx_data = 0;
        tx_thresh = 2; rx_thresh = 2; dma_tx_lvl = 0; dma_rx_lvl = 0;
        dma_tx_en = 0; dma_rx_en = 0; irq_en = 5'h1F;
        do_reset();
        chk("R11 tx_count", tx_count, 0);
        chk("R11 rx_count", rx_count, 0);
        chk("R11 raw", irq_raw, 5'b00001);
        chk("R11 rdata", bus_rdata, 0);

        foreach (VECS[i]) begin
            cyc(VECS[i].wr, VECS[i].data, VECS[i].rd, VECS[i].push, VECS[i].data, VECS[i].pop);
            chk($sformatf("R1 table %0d tx_count", i), tx_count, VECS[i].etx);
            chk($sformatf("R1 table %0d rx_count", i), rx_count, VECS[i].erx);
            chk($sformatf("R2 R3 R6 table %0d raw", i), irq_raw, VECS[i].eraw);
            if (VECS[i].chkrd) chk($sformatf("R1 R6 table %0d rdata", i), bus_rdata, VECS[i].erd);
        end

        // transmit overflow
        do_reset();
        for (int i = 0; i < 9; i++) cyc(1, 32'h100 + i, 0, 0, 0, 0);
        chk("R4 tx full count", tx_count, 8);
        chk("R4 txo set", irq_raw[1], 1);
        clr_txo = 1; @(negedge clk); clr_txo = 0;
        chk("R4 txo cleared", irq_raw[1], 0);
        cyc(1, 32'hDEAD, 0, 0, 0, 1);
        chk("R10 full swap count", tx_count, 8);
        chk("R10 full swap no txo", irq_raw[1], 0);
        for (int i = 0; i < 8; i++) begin
            chk("R1 tx order", sh_tx_data, (i < 7) ? 32'h101 + i : 32'hDEAD);
            cyc(0, 0, 0, 0, 0, 1);
        end
        chk("R1 tx drained", tx_count, 0);

        // receive overflow
        for (int i = 0; i < 9; i++) cyc(0, 0, 0, 1, 32'h200 + i, 0);
        chk("R5 rx full count", rx_count, 8);
        chk("R5 rxo set", irq_raw[3], 1);
        chk("R3 drain at full", irq_raw[4], 1);
        for (int i = 0; i < 8; i++) begin
            cyc(0, 0, 1, 0, 0, 0);
            chk("R1 R5 rx order", bus_rdata, 32'h200 + i);
        end
        chk("R5 rxo sticky", irq_raw[3], 1);
        clr_rxo = 1; @(negedge clk); clr_rxo = 0;
        chk("R5 rxo cleared", irq_raw[3], 0);

        // empty pass-through
        cyc(0, 0, 1, 1, 32'h3C3C, 0);
        chk("R10 pass data", bus_rdata, 32'h3C3C);
        chk("R10 pass count", rx_count, 0);
        chk("R10 pass no unf", irq_raw[2], 0);

        // underflow with clear in same cycle: set wins
        clr_rxu = 1; cyc(0, 0, 1, 0, 0, 0);
        chk("R6 unf zero", bus_rdata, 0);
        chk("R6 set beats clear", irq_raw[2], 1);

        // DMA transmit level
        dma_tx_en = 1; dma_tx_lvl = 3; @(negedge clk);
        chk("R7 tx req at 0", dma_tx_req, 1);
        for (int i = 0; i < 4; i++) cyc(1, i, 0, 0, 0, 0);
        chk("R7 tx req at 4 lvl 3", dma_tx_req, 0);
        dma_tx_lvl = 4; @(negedge clk);
        chk("R7 tx req at 4 lvl 4", dma_tx_req, 1);
        dma_tx_en = 0; @(negedge clk);
        chk("R7 tx req disabled", dma_tx_req, 0);

        // DMA receive level
        dma_rx_en = 1; dma_rx_lvl = 1; @(negedge clk);
        chk("R8 rx req at 0", dma_rx_req, 0);
        cyc(0, 0, 0, 1, 1, 0);
        chk("R8 rx req at 1", dma_rx_req, 0);
        cyc(0, 0, 0, 1, 2, 0);
        chk("R8 rx req at 2", dma_rx_req, 1);
        dma_rx_en = 0; @(negedge clk);
        chk("R8 rx req disabled", dma_rx_req, 0);

        // masking: raw now has bit2 set, tx_count 4 above thresh 2
        irq_en = 5'b0; @(negedge clk);
        chk("R9 all off", irq, 0);
        irq_en = 5'b00100; @(negedge clk);
        chk("R9 masked", irq_masked, 5'b00100);
        chk("R9 irq on", irq, 1);
        irq_en = 5'b00001; @(negedge clk);
        chk("R9 refill off", irq, 0);
        tx_thresh = 4; @(negedge clk);
        chk("R2 refill at equal", irq_raw[0], 1);
        chk("R9 irq follows refill", irq, 1);
        rx_thresh = 2; @(negedge clk);
        chk("R3 drain at equal", irq_raw[4], 0);
        rx_thresh = 1; @(negedge clk);
        chk("R3 drain above", irq_raw[4], 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule